// File: doc/BRIEF.md
# Data Port Quadlet Packer and Splitter

This block sits between a narrow external data port and the 32-bit quadlet path of a serial-bus link. On the transmit side it collects port words, one per strobe, and stacks them into quadlets. The first word goes into the most significant end. The port runs either 16 bits wide or 8 bits wide (lane-8 mode), and the mode can change at run time. An optional swap control reverses all four bytes of each finished quadlet. When a transfer ends with a partial quadlet, the missing low-order bytes are filled with zeros and the quadlet is sent.

On the receive side it takes a whole quadlet and plays it back onto the port one word per cycle. It uses the same word order and the same optional byte reversal. It drives output enables per byte lane, so in lane-8 mode the upper lines are released. A speed check flags any speed code above 200 Mbps while lane-8 mode is selected. A change to the lane or swap control discards any partial work in either direction.

Top module: `dmq_port_top`

## Requirements
- R1: In 16-bit mode two strobed words form one quadlet with the first word in bits 31:16 (0xAB01 then 0xCD02 gives 0xAB01CD02). `q_valid` is a single-cycle pulse in the cycle after the clock edge that takes the completing strobe.
- R2: With `cfg_swap` set, the emitted quadlet is fully byte reversed, so bits 7:0 move to 31:24. The words 0xAB01 and 0xCD02 give 0x02CD01AB.
- R3: With `cfg_byte` set, only `tx_data[7:0]` is sampled, and four strobes form a quadlet, first byte in bits 31:24. Bits 15:8 have no effect on the result.
- R4: Lane-8 mode with swap gives the fully reversed quadlet (bytes 0xAB,0x01,0xCD,0x02 give 0x02CD01AB).
- R5: When `tx_end` is asserted, a partial quadlet (including the word strobed in the same cycle) is emitted with zeros in its unfilled low-order bytes. Swap is applied after the padding. `tx_end` with nothing held emits nothing.
- R6: When `cfg_byte` or `cfg_swap` differs from its value in the previous cycle, any partial transmit accumulation is discarded without being emitted. A strobe in that same cycle starts a fresh quadlet in the new mode.
- R7: In 16-bit mode, a quadlet loaded by `rx_load` is played out as two words on `port_out`, bits 31:16 first. The first word appears in the cycle after the load edge, with `port_oe` = 2'b11 and `rx_word_valid` high. With swap set, the reversed quadlet is split instead.
- R8: In lane-8 mode a loaded quadlet is played out as four bytes on `port_out[7:0]`, bits 31:24 first, while `port_out[15:8]` is zero and `port_oe` = 2'b01. When idle, `port_oe` = 2'b00.
- R9: `speed_err` rises one cycle after `cfg_byte`=1 with `cfg_speed` of 2 (400 Mbps) or 3 (800 Mbps). Codes 0 (100 Mbps) and 1 (200 Mbps) give no error, and 16-bit mode never gives an error.
- R10: After reset `q_valid`, `q_data`, `port_oe`, `port_out`, `rx_word_valid`, `rx_busy` and `speed_err` are all zero.
- R11: `rx_busy` is high while words of a loaded quadlet remain to be played out. An `rx_load` while busy is ignored, and the sequence under way completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 1 | Lane-8 mode select |
| cfg_swap | input | 1 | Full byte reversal of each quadlet |
| cfg_speed | input | 2 | Link speed code, 0..3 = 100/200/400/800 Mbps |
| tx_data | input | 16 | Transmit port word |
| tx_stb | input | 1 | Transmit word strobe |
| tx_end | input | 1 | End of transfer, flushes a partial quadlet |
| q_data | output | 32 | Assembled quadlet |
| q_valid | output | 1 | Quadlet valid pulse |
| rx_quad | input | 32 | Receive quadlet to split |
| rx_load | input | 1 | Load `rx_quad` when not busy |
| rx_busy | output | 1 | Receive words still pending |
| port_out | output | 16 | Receive word driven to the port |
| port_oe | output | 2 | Output enable per byte lane, bit 1 = upper |
| rx_word_valid | output | 1 | `port_out` holds a receive word |
| speed_err | output | 1 | Speed too high for lane-8 mode |

## Verification
The hardest case to reach is a mode change that lands while a partial quadlet is held. If the discard is missing, the stale bytes show up only as a corrupted later quadlet. The stimulus strobes two bytes in lane-8 mode, switches to 16-bit mode in an idle cycle, and then sends a complete word pair. It checks that no pulse comes at the switch and that the next quadlet holds only the new words. A second load issued while a byte sequence is mid-flight covers the ignored-load case.

// File: rtl/dmq_pkg.sv
package dmq_pkg;
    typedef enum logic [1:0] {
        SPD_100 = 2'd0,
        SPD_200 = 2'd1,
        SPD_400 = 2'd2,
        SPD_800 = 2'd3
    } spd_e;

    typedef struct packed {
        logic lane8;
        logic swap;
    } mode_t;
endpackage

// File: rtl/dmq_byte_rev.sv
module dmq_byte_rev #(
    parameter int LANE_W = 8,
    parameter int QUAD_W = 32
) (
    input  logic [QUAD_W-1:0] din,
    output logic [QUAD_W-1:0] dout
);
    localparam int LANES = QUAD_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/dmq_mode_ctrl.sv
module dmq_mode_ctrl
    import dmq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_byte,
    input  logic       cfg_swap,
    input  logic [1:0] cfg_speed,
    output logic       mode_chg,
    output logic       speed_err
);
    typedef struct packed {
        mode_t act;
        logic  err;
    } st_t;

    st_t r_d, r_q;
    mode_t cfg_now;

    always_comb begin
        cfg_now.lane8 = cfg_byte;
        cfg_now.swap  = cfg_swap;
        r_d       = r_q;
        r_d.act   = cfg_now;
        r_d.err   = cfg_byte && (spd_e'(cfg_speed) >= SPD_400);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_chg  = (cfg_now != r_q.act);
    assign speed_err = r_q.err;

    AST_SPEED_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        speed_err |-> $past(cfg_byte && cfg_speed[1])); // R9
    AST_NO_ERR_WORD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_byte) |-> !speed_err); // R9
endmodule

// File: rtl/dmq_tx_packer.sv
module dmq_tx_packer #(
    parameter int LANE_W = 8,
    parameter int WORD_W = 16,
    parameter int QUAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane8,
    input  logic              swap,
    input  logic              mode_chg,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_stb,
    input  logic              tx_end,
    output logic [QUAD_W-1:0] q_data,
    output logic              q_valid
);
    localparam int LANES      = QUAD_W / LANE_W;
    localparam int WORD_LANES = WORD_W / LANE_W;
    localparam int CNT_W      = $clog2(LANES + 1);

    typedef struct packed {
        logic [QUAD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic [QUAD_W-1:0] q;
        logic              qswap;
        logic              vld;
    } st_t;

    st_t r_d, r_q;
    logic [QUAD_W-1:0] base_acc, acc2, q_rev;
    logic [CNT_W-1:0]  base_cnt, cnt2;
    int                pad_sh;

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        base_acc = mode_chg ? '0 : r_q.acc;
        base_cnt = mode_chg ? '0 : r_q.cnt;
        acc2     = base_acc;
        cnt2     = base_cnt;
        if (tx_stb) begin
            if (lane8) begin
                acc2 = {base_acc[QUAD_W-LANE_W-1:0], tx_data[LANE_W-1:0]};
                cnt2 = base_cnt + CNT_W'(1);
            end else begin
                acc2 = {base_acc[QUAD_W-WORD_W-1:0], tx_data};
                cnt2 = base_cnt + CNT_W'(WORD_LANES);
            end
        end
        pad_sh = LANE_W * (LANES - int'(cnt2));
        r_d.acc = acc2;
        r_d.cnt = cnt2;
        if (cnt2 == CNT_W'(LANES)) begin
            r_d.q     = acc2;
            r_d.qswap = swap;
            r_d.vld   = 1'b1;
            r_d.acc   = '0;
            r_d.cnt   = '0;
        end else if (tx_end && (cnt2 != '0)) begin
            r_d.q     = acc2 << pad_sh;
            r_d.qswap = swap;
            r_d.vld   = 1'b1;
            r_d.acc   = '0;
            r_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    dmq_byte_rev #(.LANE_W(LANE_W), .QUAD_W(QUAD_W)) u_rev (
        .din  (r_q.q),
        .dout (q_rev)
    );

    assign q_data  = r_q.qswap ? q_rev : r_q.q;
    assign q_valid = r_q.vld;

    AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CNT_W'(LANES)); // R5
    AST_TX_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> $past(tx_stb || tx_end)); // R1
    AST_TX_CHG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_chg && !tx_stb) |-> (r_q.cnt == '0 && !q_valid)); // R6
endmodule

// File: rtl/dmq_rx_splitter.sv
module dmq_rx_splitter #(
    parameter int LANE_W = 8,
    parameter int WORD_W = 16,
    parameter int QUAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane8,
    input  logic              swap,
    input  logic              mode_chg,
    input  logic [QUAD_W-1:0] rx_quad,
    input  logic              rx_load,
    output logic              rx_busy,
    output logic [WORD_W-1:0] port_out,
    output logic [1:0]        port_oe,
    output logic              rx_word_valid
);
    localparam int LANES      = QUAD_W / LANE_W;
    localparam int WORD_LANES = WORD_W / LANE_W;
    localparam int CNT_W      = $clog2(LANES + 1);

    typedef struct packed {
        logic [QUAD_W-1:0] sr;
        logic [CNT_W-1:0]  left;
        logic              narrow;
        logic [WORD_W-1:0] out;
        logic [1:0]        oe;
        logic              vld;
    } st_t;

    st_t r_d, r_q;
    logic [QUAD_W-1:0] quad_rev, quad_st;
    logic              busy;

    dmq_byte_rev #(.LANE_W(LANE_W), .QUAD_W(QUAD_W)) u_rev (
        .din  (rx_quad),
        .dout (quad_rev)
    );

    always_comb begin
        r_d     = r_q;
        busy    = (r_q.left != '0);
        quad_st = swap ? quad_rev : rx_quad;
        if (mode_chg) begin
            r_d.left = '0;
            r_d.vld  = 1'b0;
            r_d.oe   = 2'b00;
            r_d.out  = '0;
        end else if (rx_load && !busy) begin
            r_d.narrow = lane8;
            r_d.vld    = 1'b1;
            if (lane8) begin
                r_d.out  = {{(WORD_W-LANE_W){1'b0}}, quad_st[QUAD_W-1 -: LANE_W]};
                r_d.sr   = quad_st << LANE_W;
                r_d.left = CNT_W'(LANES - 1);
                r_d.oe   = 2'b01;
            end else begin
                r_d.out  = quad_st[QUAD_W-1 -: WORD_W];
                r_d.sr   = quad_st << WORD_W;
                r_d.left = CNT_W'(LANES / WORD_LANES - 1);
                r_d.oe   = 2'b11;
            end
        end else if (busy) begin
            r_d.vld  = 1'b1;
            r_d.left = r_q.left - CNT_W'(1);
            if (r_q.narrow) begin
                r_d.out = {{(WORD_W-LANE_W){1'b0}}, r_q.sr[QUAD_W-1 -: LANE_W]};
                r_d.sr  = r_q.sr << LANE_W;
                r_d.oe  = 2'b01;
            end else begin
                r_d.out = r_q.sr[QUAD_W-1 -: WORD_W];
                r_d.sr  = r_q.sr << WORD_W;
                r_d.oe  = 2'b11;
            end
        end else begin
            r_d.vld = 1'b0;
            r_d.oe  = 2'b00;
            r_d.out = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_busy       = busy;
    assign port_out      = r_q.out;
    assign port_oe       = r_q.oe;
    assign rx_word_valid = r_q.vld;

    AST_RX_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !port_oe[1] |-> (port_out[WORD_W-1:LANE_W] == '0)); // R8
    AST_RX_VALID_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_word_valid |-> port_oe[0]); // R7
    AST_RX_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.left < CNT_W'(LANES)); // R11
    AST_RX_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_load && !mode_chg) |=> (r_q.left == $past(r_q.left) - CNT_W'(1))); // R11
endmodule

// File: rtl/dmq_port_top.sv
module dmq_port_top #(
    parameter int LANE_W = 8,
    parameter int WORD_W = 16,
    parameter int QUAD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_byte,
    input  logic              cfg_swap,
    input  logic [1:0]        cfg_speed,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_stb,
    input  logic              tx_end,
    output logic [QUAD_W-1:0] q_data,
    output logic              q_valid,
    input  logic [QUAD_W-1:0] rx_quad,
    input  logic              rx_load,
    output logic              rx_busy,
    output logic [WORD_W-1:0] port_out,
    output logic [1:0]        port_oe,
    output logic              rx_word_valid,
    output logic              speed_err
);
    logic mode_chg;

    dmq_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_byte  (cfg_byte),
        .cfg_swap  (cfg_swap),
        .cfg_speed (cfg_speed),
        .mode_chg  (mode_chg),
        .speed_err (speed_err)
    );

    dmq_tx_packer #(.LANE_W(LANE_W), .WORD_W(WORD_W), .QUAD_W(QUAD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane8    (cfg_byte),
        .swap     (cfg_swap),
        .mode_chg (mode_chg),
        .tx_data  (tx_data),
        .tx_stb   (tx_stb),
        .tx_end   (tx_end),
        .q_data   (q_data),
        .q_valid  (q_valid)
    );

    dmq_rx_splitter #(.LANE_W(LANE_W), .WORD_W(WORD_W), .QUAD_W(QUAD_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane8         (cfg_byte),
        .swap          (cfg_swap),
        .mode_chg      (mode_chg),
        .rx_quad       (rx_quad),
        .rx_load       (rx_load),
        .rx_busy       (rx_busy),
        .port_out      (port_out),
        .port_oe       (port_oe),
        .rx_word_valid (rx_word_valid)
    );

    AST_TX_RX_INDEPENDENT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe == 2'b11) |-> $past(!cfg_byte)); // R8
endmodule

// File: tb/tb_dmq_port_top.sv
module tb_dmq_port_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_byte = 1'b0, cfg_swap = 1'b0;
    logic [1:0]  cfg_speed = 2'd0;
    logic [15:0] tx_data = '0;
    logic        tx_stb = 1'b0, tx_end = 1'b0;
    logic [31:0] q_data;
    logic        q_valid;
    logic [31:0] rx_quad = '0;
    logic        rx_load = 1'b0;
    logic        rx_busy;
    logic [15:0] port_out;
    logic [1:0]  port_oe;
    logic        rx_word_valid;
    logic        speed_err;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    dmq_port_top dut (.*);

    // vector: byte(1) swap(1) nwords(3) w0 w1 w2 w3 (16 each) expected(32)
    localparam int NV = 8;
    localparam logic [100:0] TV [NV] = '{
        {1'b0, 1'b0, 3'd2, 16'hAB01, 16'hCD02, 16'h0000, 16'h0000, 32'hAB01CD02}, // R1
        {1'b0, 1'b1, 3'd2, 16'hAB01, 16'hCD02, 16'h0000, 16'h0000, 32'h02CD01AB}, // R2
        {1'b1, 1'b0, 3'd4, 16'hFFAB, 16'hEE01, 16'hDDCD, 16'hCC02, 32'hAB01CD02}, // R3
        {1'b1, 1'b1, 3'd4, 16'h55AB, 16'h6601, 16'h77CD, 16'h8802, 32'h02CD01AB}, // R4
        {1'b0, 1'b0, 3'd1, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 32'h12340000}, // R5
        {1'b1, 1'b0, 3'd3, 16'h0011, 16'h0022, 16'h0033, 16'h0000, 32'h11223300}, // R5
        {1'b1, 1'b1, 3'd1, 16'h005A, 16'h0000, 16'h0000, 16'h0000, 32'h0000005A}, // R5
        {1'b0, 1'b1, 3'd1, 16'hBEEF, 16'h0000, 16'h0000, 16'h0000, 32'h0000EFBE}  // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [15:0] d, input logic e);
        @(negedge clk);
        tx_stb  = 1'b1;
        tx_data = d;
        tx_end  = e;
    endtask

    task automatic idle();
        @(negedge clk);
        tx_stb  = 1'b0;
        tx_end  = 1'b0;
        rx_load = 1'b0;
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 q_valid", {31'd0, q_valid}, 32'd0);
        chk("R10 q_data", q_data, 32'd0);
        chk("R10 port", {14'd0, port_oe, port_out}, 32'd0);
        chk("R10 rx flags", {29'd0, rx_word_valid, rx_busy, speed_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  nw;
            logic [15:0] w [4];
            nw = TV[v][98:96];
            w[0] = TV[v][95:80]; w[1] = TV[v][79:64];
            w[2] = TV[v][63:48]; w[3] = TV[v][47:32];
            @(negedge clk);
            cfg_byte = TV[v][100];
            cfg_swap = TV[v][99];
            idle();
            for (int k = 0; k < 4; k++)
                if (k < int'(nw)) strobe(w[k], (k == int'(nw) - 1));
            idle();
            chk($sformatf("R1/R2/R3/R4/R5 vec%0d valid", v), {31'd0, q_valid}, 32'd1);
            chk($sformatf("R1/R2/R3/R4/R5 vec%0d data", v), q_data, TV[v][31:0]);
            @(negedge clk);
            chk($sformatf("R1 vec%0d pulse ends", v), {31'd0, q_valid}, 32'd0);
        end

        // R5: end with nothing held emits nothing
        @(negedge clk); cfg_byte = 1'b0; cfg_swap = 1'b0;
        idle();
        @(negedge clk); tx_end = 1'b1;
        idle();
        chk("R5 empty end", {31'd0, q_valid}, 32'd0);

        // R6: mode change discards partial bytes
        @(negedge clk); cfg_byte = 1'b1;
        idle();
        strobe(16'h0011, 1'b0);
        strobe(16'h0022, 1'b0);
        idle();
        cfg_byte = 1'b0;
        @(negedge clk);
        chk("R6 no emit on change", {31'd0, q_valid}, 32'd0);
        strobe(16'h3344, 1'b0);
        strobe(16'h5566, 1'b0);
        idle();
        chk("R6 fresh quadlet valid", {31'd0, q_valid}, 32'd1);
        chk("R6 fresh quadlet data", q_data, 32'h33445566);

        // R7: receive word mode, no swap then swap
        @(negedge clk); rx_quad = 32'hAB01CD02; rx_load = 1'b1;
        idle();
        chk("R7 w0", {13'd0, rx_word_valid, port_oe, port_out}, {13'd0, 1'b1, 2'b11, 16'hAB01});
        @(negedge clk);
        chk("R7 w1", {13'd0, rx_word_valid, port_oe, port_out}, {13'd0, 1'b1, 2'b11, 16'hCD02});
        @(negedge clk);
        chk("R8 idle oe", {13'd0, rx_word_valid, port_oe, port_out}, 32'd0);
        cfg_swap = 1'b1;
        idle();
        rx_load = 1'b1;
        idle();
        chk("R7 swap w0", {16'd0, port_out}, 32'h000002CD);
        @(negedge clk);
        chk("R7 swap w1", {16'd0, port_out}, 32'h000001AB);

        // R8 and R11: byte receive with an ignored second load
        @(negedge clk); cfg_swap = 1'b0; cfg_byte = 1'b1;
        idle();
        rx_load = 1'b1;
        @(negedge clk);
        rx_quad = 32'hFFFFFFFF;
        chk("R8 b0", {13'd0, rx_word_valid, port_oe, port_out}, {13'd0, 1'b1, 2'b01, 16'h00AB});
        chk("R11 busy", {31'd0, rx_busy}, 32'd1);
        @(negedge clk);
        rx_load = 1'b0;
        chk("R11 b1", {16'd0, port_out}, 32'h00000001);
        @(negedge clk);
        chk("R8 b2", {14'd0, port_oe, port_out}, {14'd0, 2'b01, 16'h00CD});
        @(negedge clk);
        chk("R8 b3", {14'd0, port_oe, port_out}, {14'd0, 2'b01, 16'h0002});
        @(negedge clk);
        chk("R11 done", {29'd0, rx_word_valid, rx_busy, port_oe[0]}, 32'd0);

        // R9 speed check
        cfg_speed = 2'd2;
        @(negedge clk);
        chk("R9 400 lane8", {31'd0, speed_err}, 32'd1);
        cfg_speed = 2'd1;
        @(negedge clk);
        chk("R9 200 lane8", {31'd0, speed_err}, 32'd0);
        cfg_speed = 2'd3;
        @(negedge clk);
        chk("R9 800 lane8", {31'd0, speed_err}, 32'd1);
        cfg_byte = 1'b0;
        @(negedge clk);
        chk("R9 800 word", {31'd0, speed_err}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule